// File: doc/BRIEF.md
# Compare-Match Timer Group

This block holds a small group of up-counting timer channels behind one register port. Each channel divides the system clock by a selectable prescale ratio and advances its counter once per prescaled tick. When the counter equals its compare value it goes back to zero on the next tick and raises a match flag. A flag together with the channel's interrupt enable drives that channel's interrupt line. All channels share one run-control register at offset 0, and each channel is gated by one bit of it. The position of that bit is a per-channel parameter.

One parameter picks the narrow (16-bit counter) or wide (32-bit counter) variant. The variant sets the register stride, the access sizes that are accepted, the flag and enable bit positions, and which control bits are stored. Software programs compare, counter and control words, sets its channel's run bit and takes the interrupt. It then clears the flag by writing the control word with the flag bits at zero.

Top module: `cmt_group`

## Requirements
- R1: After reset every control word reads 0, every counter reads 0, every compare reads all ones for the channel width, the run-control register reads 0 and all interrupt lines are low.
- R2: The run-control register is at byte 0. Channel k starts at byte CH_BASE + k*CH_SPAN. Its control, counter and compare words follow at register index 0, 1 and 2, with a stride of 2 bytes (narrow) or 4 bytes (wide). Any other address reads 0 and ignores writes.
- R3: bus_size 0 is a 16-bit access and 1 is a 32-bit access. The wide variant takes 32-bit accesses for counter and compare and 16-bit accesses for control and run-control. The narrow variant takes only 16-bit accesses. An access of the wrong size reads 0 and its write is ignored.
- R4: Channel k counts only while run-control bit START_BITS[4k+3:4k] is 1. Run-control bits that belong to no channel read 0. A stopped channel keeps its counter value.
- R5: On each tick the counter goes up by one. A tick that finds counter equal to compare sets the counter to 0 and sets the match flag, so one period is compare+1 ticks.
- R6: Control bits [1:0] set the prescale ratio: 0, 1, 2 and 3 give 8, 32, 128 and 512 clocks. While a channel is stopped its prescaler is held at zero, so its first count comes exactly one full ratio of clocks after the run bit is written.
- R7: The match flag is control bit 7 (narrow) or bit 15 (wide). The wide variant also sets bit 14 when a tick takes the counter from all ones to 0 with no match. A control write with a flag bit at 0 clears that flag. A write with the flag bit at 1 leaves it unchanged, so software never sets a flag.
- R8: A channel's interrupt is high while its interrupt-enable bit is 1 and any of its flags is 1. Enable is bit 6 (narrow) or bit 5 (wide). Writing 0 to the control word drops the interrupt.
- R9: A counter write in a cycle that also has a tick loads the written value. In that cycle there is no increment and no flag.
- R10: The control word stores only bits 6, 1 and 0 (narrow) or bits 8, 7, 5, 2, 1 and 0 (wide). All other bits read back 0, except the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | AW | Byte address of the access |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_size | input | 1 | Access size: 0 = 16-bit, 1 = 32-bit |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address, combinational |
| irq | output | NCH | One interrupt per channel |

## Verification
The bench builds two instances. The first is a wide two-channel group whose run bits are moved to positions 2 and 5. This exposes the 4-byte stride, the size rules, the overflow flag at bit 14 and the masking of run bits that belong to no channel. The second is a narrow one-channel group. It covers the 2-byte stride, the flag at bit 7, the enable at bit 6 and the slowest 512-clock prescale. The timing checks count clocks from the run-bit write, so an off-by-one in the prescaler, a missed prescaler reset on stop, or an increment that beats a counter write in the same cycle all show up as a wrong counter value.

// File: rtl/cmt_pkg.sv
// Shared definitions for the compare-match timer group.
// Assumes: prescale codes are two bits wide; the largest ratio fits PRE_W bits.
package cmt_pkg;

    localparam int PRE_W = 9;

    typedef enum logic [1:0] {
        IDX_CSR = 2'd0,
        IDX_CNT = 2'd1,
        IDX_CMP = 2'd2
    } reg_idx_e;

    // Terminal count of the prescaler for a given ratio code.
    function automatic logic [PRE_W-1:0] div_last(input logic [1:0] code);
        case (code)
            2'd0:    return PRE_W'(7);
            2'd1:    return PRE_W'(31);
            2'd2:    return PRE_W'(127);
            default: return PRE_W'(511);
        endcase
    endfunction

endpackage

// File: rtl/cmt_prescaler.sv
// Clock divider for one channel: emits a one-cycle tick every ratio clocks.
// Assumes: held at zero while the channel is stopped, so a restart always
// waits one full ratio before the first tick.
module cmt_prescaler
    import cmt_pkg::*;
#(
    parameter int PW = PRE_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] code,
    output logic       tick
);

    logic [PW-1:0] pre_q;
    logic [PW-1:0] last;

    assign last = PW'(div_last(code));
    assign tick = run && (pre_q == last);

    // Divider count: cleared when stopped, wraps at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre_q <= '0;
        end else if (pre_q == last) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

endmodule

// File: rtl/cmt_chan.sv
// One timer channel: control word, counter, compare value, flags and interrupt.
// Assumes: write strobes are already decoded and size-checked by the parent.
module cmt_chan
    import cmt_pkg::*;
#(
    parameter bit WIDE = 1'b1,
    parameter int CW   = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          wr_csr,
    input  logic          wr_cnt,
    input  logic          wr_cmp,
    input  logic [CW-1:0] wdata,
    output logic [15:0]   csr_val,
    output logic [CW-1:0] cnt_q,
    output logic [CW-1:0] cmp_q,
    output logic          irq
);

    localparam int          FLAG_M = WIDE ? 15 : 7;
    localparam int          FLAG_O = 14;
    localparam int          IE_B   = WIDE ? 5 : 6;
    localparam logic [15:0] KEEP_M = WIDE ? 16'h01A7 : 16'h0043;

    logic [15:0] ctrl_q;
    logic        tick;
    logic        is_match;
    logic        at_top;
    logic        match_f;
    logic        ovf_f;
    logic        cnt_step;

    cmt_prescaler #(.PW(PRE_W)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .code (ctrl_q[1:0]),
        .tick (tick)
    );

    assign is_match = (cnt_q == cmp_q);
    assign at_top   = &cnt_q;
    assign cnt_step = tick && !wr_cnt;

    // Control word: keeps only the bits this variant defines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_csr) begin
            ctrl_q <= wdata[15:0] & KEEP_M;
        end
    end

    // Compare value: resets to the largest count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '1;
        end else if (wr_cmp) begin
            cmp_q <= wdata;
        end
    end

    // Counter: a software write wins over a tick in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_cnt) begin
            cnt_q <= wdata;
        end else if (tick) begin
            cnt_q <= is_match ? '0 : cnt_q + 1'b1;
        end
    end

    // Match flag: a set wins over a clearing write in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_f <= 1'b0;
        end else if (cnt_step && is_match) begin
            match_f <= 1'b1;
        end else if (wr_csr && !wdata[FLAG_M]) begin
            match_f <= 1'b0;
        end
    end

    generate
        if (WIDE) begin : g_ovf
            // Overflow flag: counter wrapped from all ones without a match.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ovf_f <= 1'b0;
                end else if (cnt_step && !is_match && at_top) begin
                    ovf_f <= 1'b1;
                end else if (wr_csr && !wdata[FLAG_O]) begin
                    ovf_f <= 1'b0;
                end
            end
        end else begin : g_no_ovf
            assign ovf_f = 1'b0;
        end
    endgenerate

    assign csr_val = ctrl_q | (16'(match_f) << FLAG_M) | (16'(ovf_f) << FLAG_O);
    assign irq     = ctrl_q[IE_B] && (match_f || ovf_f);

endmodule

// File: rtl/cmt_group.sv
// Timer group top: run-control register, address decode, size checks, read
// multiplexer and NCH channel instances.
// Assumes: byte addresses; reads are combinational; each START_BITS nibble
// names a distinct run-control bit.
module cmt_group
    import cmt_pkg::*;
#(
    parameter bit               WIDE       = 1'b1,
    parameter int               NCH        = 2,
    parameter int               AW         = 8,
    parameter logic [AW-1:0]    CH_BASE    = 8'h10,
    parameter logic [AW-1:0]    CH_SPAN    = 8'h10,
    parameter logic [NCH*4-1:0] START_BITS = 8'h10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  bus_addr,
    input  logic           bus_wr,
    input  logic           bus_size,
    input  logic [31:0]    bus_wdata,
    output logic [31:0]    bus_rdata,
    output logic [NCH-1:0] irq
);

    localparam int CW     = WIDE ? 32 : 16;
    localparam int SLOG   = WIDE ? 2 : 1;
    localparam int STRIDE = 1 << SLOG;

    function automatic logic [15:0] mk_mask();
        logic [15:0] m;
        m = '0;
        for (int k = 0; k < NCH; k++) begin
            m[START_BITS[k*4 +: 4]] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [15:0] START_MASK = mk_mask();

    logic [15:0]              start_q;
    logic                     start_hit;
    logic [NCH-1:0]           ch_run;
    logic [NCH-1:0]           ch_wr_csr;
    logic [NCH-1:0]           ch_wr_cnt;
    logic [NCH-1:0]           ch_wr_cmp;
    logic [NCH-1:0][15:0]     ch_csr;
    logic [NCH-1:0][CW-1:0]   ch_cnt;
    logic [NCH-1:0][CW-1:0]   ch_cmp;
    logic [NCH-1:0][31:0]     ch_rd;

    assign start_hit = (bus_addr == '0) && !bus_size;

    // Shared run-control register: only bits owned by a channel are kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
        end else if (bus_wr && start_hit) begin
            start_q <= bus_wdata[15:0] & START_MASK;
        end
    end

    generate
        for (genvar k = 0; k < NCH; k++) begin : g_ch
            localparam logic [AW-1:0] BASE = AW'(CH_BASE + k * CH_SPAN);

            logic [AW-1:0] rel;
            logic [1:0]    idx;
            logic          hit;
            logic          ok;
            logic [31:0]   rd_v;

            assign rel = bus_addr - BASE;
            assign idx = 2'(rel >> SLOG);
            assign hit = (bus_addr >= BASE) && (rel < AW'(3 * STRIDE))
                         && ((rel & AW'(STRIDE - 1)) == '0);
            assign ok  = hit && (bus_size == (WIDE && (idx != IDX_CSR)));

            assign ch_wr_csr[k] = bus_wr && ok && (idx == IDX_CSR);
            assign ch_wr_cnt[k] = bus_wr && ok && (idx == IDX_CNT);
            assign ch_wr_cmp[k] = bus_wr && ok && (idx == IDX_CMP);
            assign ch_run[k]    = start_q[START_BITS[k*4 +: 4]];

            cmt_chan #(.WIDE(WIDE), .CW(CW)) u_chan (
                .clk    (clk),
                .rst_n  (rst_n),
                .run    (ch_run[k]),
                .wr_csr (ch_wr_csr[k]),
                .wr_cnt (ch_wr_cnt[k]),
                .wr_cmp (ch_wr_cmp[k]),
                .wdata  (bus_wdata[CW-1:0]),
                .csr_val(ch_csr[k]),
                .cnt_q  (ch_cnt[k]),
                .cmp_q  (ch_cmp[k]),
                .irq    (irq[k])
            );

            // Per-channel read data, zero when this channel is not addressed.
            always_comb begin
                rd_v = '0;
                if (ok) begin
                    case (idx)
                        IDX_CSR: rd_v = {16'h0, ch_csr[k]};
                        IDX_CNT: rd_v = 32'(ch_cnt[k]);
                        IDX_CMP: rd_v = 32'(ch_cmp[k]);
                        default: rd_v = '0;
                    endcase
                end
            end

            assign ch_rd[k] = rd_v;
        end
    endgenerate

    // Read multiplexer: OR of the run-control word and every channel.
    always_comb begin
        bus_rdata = start_hit ? {16'h0, start_q} : 32'h0;
        for (int k = 0; k < NCH; k++) begin
            bus_rdata = bus_rdata | ch_rd[k];
        end
    end

endmodule

// File: rtl/cmt_group_chk.sv
// Property checker for cmt_group, attached through bind below.
// Assumes: the same parameters as the instance it is bound to.
module cmt_group_chk #(
    parameter bit            WIDE    = 1'b1,
    parameter int            NCH     = 2,
    parameter int            AW      = 8,
    parameter logic [AW-1:0] CH_BASE = 8'h10
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic [AW-1:0]                       bus_addr,
    input logic [31:0]                         bus_wdata,
    input logic [31:0]                         bus_rdata,
    input logic [NCH-1:0]                      irq,
    input logic [NCH-1:0]                      ch_run,
    input logic [NCH-1:0]                      ch_wr_cnt,
    input logic [NCH-1:0][15:0]                ch_csr,
    input logic [NCH-1:0][(WIDE?32:16)-1:0]    ch_cnt,
    input logic [NCH-1:0][(WIDE?32:16)-1:0]    ch_cmp
);

    localparam int CW   = WIDE ? 32 : 16;
    localparam int FB   = WIDE ? 15 : 7;
    localparam int IEB  = WIDE ? 5 : 6;

    // R2: the gap between run-control and the first channel reads zero.
    a_r2_gap_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != '0 && bus_addr < CH_BASE) |-> (bus_rdata == 32'h0));

    generate
        for (genvar k = 0; k < NCH; k++) begin : g_chk
            // R4: a stopped channel with no counter write keeps its count.
            a_r4_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
                (!ch_run[k] && !ch_wr_cnt[k]) |=> $stable(ch_cnt[k]));

            // R5: without a match or write the counter moves by at most one.
            a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
                (!ch_wr_cnt[k] && ch_cnt[k] != ch_cmp[k])
                |=> (ch_cnt[k] == $past(ch_cnt[k])
                     || ch_cnt[k] == CW'($past(ch_cnt[k]) + 1'b1)));

            // R7: the match flag rises only from a match, leaving the count at 0.
            a_r7_flag_from_match: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(ch_csr[k][FB])
                |-> (ch_cnt[k] == '0 && $past(ch_cnt[k]) == $past(ch_cmp[k])));

            // R8: an interrupt never shows while its enable is off.
            a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
                irq[k] |-> ch_csr[k][IEB]);

            // R9: a counter write always lands, whatever the prescaler does.
            a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
                ch_wr_cnt[k] |=> (ch_cnt[k] == $past(bus_wdata[CW-1:0])));
        end
    endgenerate

endmodule

bind cmt_group cmt_group_chk #(
    .WIDE   (WIDE),
    .NCH    (NCH),
    .AW     (AW),
    .CH_BASE(CH_BASE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq      (irq),
    .ch_run   (ch_run),
    .ch_wr_cnt(ch_wr_cnt),
    .ch_csr   (ch_csr),
    .ch_cnt   (ch_cnt),
    .ch_cmp   (ch_cmp)
);

// File: tb/cmt_group_tb.sv
// Scoreboard bench: read tasks queue expected words, a monitor compares them.
module cmt_group_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_size = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        wr32 = 1'b0;
    logic        wr16 = 1'b0;
    logic [31:0] rdata32;
    logic [31:0] rdata16;
    logic [1:0]  irq32;
    logic [0:0]  irq16;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        bit          sel;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cmt_group #(
        .WIDE(1'b1), .NCH(2), .AW(8), .CH_BASE(8'h10), .CH_SPAN(8'h10),
        .START_BITS(8'h52)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(wr32),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(rdata32),
        .irq(irq32)
    );

    cmt_group #(
        .WIDE(1'b0), .NCH(1), .AW(8), .CH_BASE(8'h10), .CH_SPAN(8'h10),
        .START_BITS(4'h0)
    ) u_dut16 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(wr16),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(rdata16),
        .irq(irq16)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Monitor: pops each expected read and compares with the addressed DUT.
    always begin
        item_t it;
        logic [31:0] got;
        wait (sb_q.size() != 0);
        it = sb_q.pop_front();
        got = it.sel ? rdata16 : rdata32;
        n_chk++;
        if (got !== it.exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
        end
    end

    task automatic wr(input bit s, input logic [7:0] a, input bit sz, input logic [31:0] d);
        bus_addr = a; bus_size = sz; bus_wdata = d;
        if (s) wr16 = 1'b1; else wr32 = 1'b1;
        @(negedge clk);
        wr16 = 1'b0; wr32 = 1'b0;
    endtask

    task automatic rd(input bit s, input logic [7:0] a, input bit sz,
                      input logic [31:0] e, input string tag);
        item_t it;
        bus_addr = a; bus_size = sz;
        #2;
        it.sel = s; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic chk(input logic [31:0] got, input logic [31:0] e, input string tag);
        n_chk++;
        if (got !== e) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, e);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(0, 8'h10, 0, 32'h0, "R1 wide csr");
        rd(0, 8'h14, 1, 32'h0, "R1 wide cnt");
        rd(0, 8'h18, 1, 32'hFFFF_FFFF, "R1 wide cmp");
        rd(0, 8'h00, 0, 32'h0, "R1 run-control");
        rd(1, 8'h14, 0, 32'h0000_FFFF, "R1 narrow cmp");
        rd(1, 8'h12, 0, 32'h0, "R1 narrow cnt");
        chk({30'h0, irq32}, 32'h0, "R1 wide irq");
        chk({31'h0, irq16}, 32'h0, "R1 narrow irq");

        // R2 unmapped and misaligned addresses
        rd(0, 8'h0C, 0, 32'h0, "R2 gap read");
        rd(0, 8'h1C, 1, 32'h0, "R2 past cmp");
        wr(0, 8'h0C, 1, 32'h1234_5678);
        rd(0, 8'h0C, 1, 32'h0, "R2 gap write ignored");
        rd(1, 8'h16, 0, 32'h0, "R2 narrow past cmp");
        rd(1, 8'h11, 0, 32'h0, "R2 narrow misaligned");
        rd(0, 8'h28, 1, 32'hFFFF_FFFF, "R2 ch1 cmp at stride 4");

        // R3 access size rules
        wr(0, 8'h18, 0, 32'h0000_1234);
        rd(0, 8'h18, 1, 32'hFFFF_FFFF, "R3 short write to cmp ignored");
        rd(0, 8'h18, 0, 32'h0, "R3 short read of cmp");
        wr(0, 8'h10, 1, 32'h0000_01A4);
        rd(0, 8'h10, 0, 32'h0, "R3 long write to csr ignored");
        rd(0, 8'h10, 1, 32'h0, "R3 long read of csr");
        rd(1, 8'h12, 1, 32'h0, "R3 narrow long read");

        // R4 run-control masking (run bits 2 and 5 only)
        wr(0, 8'h00, 0, 32'h0000_FFFF);
        rd(0, 8'h00, 0, 32'h0000_0024, "R4 unowned run bits read 0");
        wr(0, 8'h00, 0, 32'h0);

        // R10 stored control bits
        wr(0, 8'h10, 0, 32'h0000_FFFF);
        rd(0, 8'h10, 0, 32'h0000_01A7, "R10 wide csr mask");
        chk({30'h0, irq32}, 32'h0, "R7 write of 1 sets no flag");
        wr(0, 8'h10, 0, 32'h0000_01A4);

        // R5/R6 counting with compare 2, ratio 8; run write commits at edge 0
        wr(0, 8'h18, 1, 32'd2);
        wr(0, 8'h14, 1, 32'd0);
        wr(0, 8'h00, 0, 32'h0000_0004);
        idle(7);
        rd(0, 8'h14, 1, 32'd0, "R6 no tick before 8 clocks");
        rd(0, 8'h14, 1, 32'd1, "R6 first tick at 8 clocks");
        idle(14);
        rd(0, 8'h10, 0, 32'h0000_01A4, "R5 no flag before match");
        chk({30'h0, irq32}, 32'h1, "R8 irq on match");
        rd(0, 8'h10, 0, 32'h0000_81A4, "R5 R7 match flag bit 15");
        rd(0, 8'h14, 1, 32'd0, "R5 counter back to 0");
        wr(0, 8'h10, 0, 32'h0000_01A4);
        rd(0, 8'h10, 0, 32'h0000_01A4, "R7 flag cleared by 0");
        chk({30'h0, irq32}, 32'h0, "R8 irq drops after clear");

        // R4 stopped counter holds; R6 restart waits a full ratio
        wr(0, 8'h00, 0, 32'h0);
        wr(0, 8'h14, 1, 32'd1);
        idle(20);
        rd(0, 8'h14, 1, 32'd1, "R4 stopped counter holds");
        wr(0, 8'h00, 0, 32'h0000_0004);
        idle(7);
        rd(0, 8'h14, 1, 32'd1, "R6 restart no early tick");
        rd(0, 8'h14, 1, 32'd2, "R6 restart tick at 8");
        idle(6);
        // R9 write lands on the tick edge where count equals compare
        wr(0, 8'h14, 1, 32'h0000_0100);
        rd(0, 8'h14, 1, 32'h0000_0100, "R9 write beats tick");
        rd(0, 8'h10, 0, 32'h0000_01A4, "R9 no flag on write cycle");
        idle(5);
        rd(0, 8'h14, 1, 32'h0000_0100, "R5 before next tick");
        rd(0, 8'h14, 1, 32'h0000_0101, "R5 counts past compare");

        // R7 overflow flag at bit 14
        wr(0, 8'h00, 0, 32'h0);
        wr(0, 8'h14, 1, 32'hFFFF_FFFF);
        wr(0, 8'h00, 0, 32'h0000_0004);
        idle(8);
        rd(0, 8'h10, 0, 32'h0000_41A4, "R7 overflow flag bit 14");
        chk({30'h0, irq32}, 32'h1, "R8 irq on overflow");
        wr(0, 8'h10, 0, 32'h0000_81A4);
        rd(0, 8'h10, 0, 32'h0000_01A4, "R7 bit 15 write of 1 sets nothing");
        wr(0, 8'h00, 0, 32'h0);

        // R4 channel 1 on run bit 5 runs alone
        wr(0, 8'h14, 1, 32'd5);
        wr(0, 8'h00, 0, 32'h0000_0020);
        idle(20);
        rd(0, 8'h24, 1, 32'd2, "R4 ch1 counts on bit 5");
        rd(0, 8'h14, 1, 32'd5, "R4 ch0 idle");
        chk({30'h0, irq32}, 32'h0, "R8 no irq without flags");
        wr(0, 8'h00, 0, 32'h0);

        // Narrow variant: flag bit 7, enable bit 6
        wr(1, 8'h14, 0, 32'd1);
        wr(1, 8'h00, 0, 32'h0000_0001);
        idle(16);
        rd(1, 8'h10, 0, 32'h0000_0080, "R7 narrow flag bit 7");
        chk({31'h0, irq16}, 32'h0, "R8 irq held off by enable");
        wr(1, 8'h10, 0, 32'h0000_00C0);
        rd(1, 8'h10, 0, 32'h0000_00C0, "R8 enable bit 6 kept flag");
        chk({31'h0, irq16}, 32'h1, "R8 narrow irq");
        wr(1, 8'h10, 0, 32'h0);
        rd(1, 8'h10, 0, 32'h0, "R8 zero control clears");
        chk({31'h0, irq16}, 32'h0, "R8 zero control drops irq");

        // R6 ratio 512 on the narrow channel
        wr(1, 8'h00, 0, 32'h0);
        wr(1, 8'h12, 0, 32'h0);
        wr(1, 8'h14, 0, 32'h0000_FFFF);
        wr(1, 8'h10, 0, 32'h0000_FFFF);
        rd(1, 8'h10, 0, 32'h0000_0043, "R10 narrow csr mask");
        wr(1, 8'h00, 0, 32'h0000_0001);
        idle(511);
        rd(1, 8'h12, 0, 32'd0, "R6 ratio 512 no early tick");
        rd(1, 8'h12, 0, 32'd1, "R6 ratio 512 tick");
        wr(1, 8'h00, 0, 32'h0);

        wait (sb_q.size() == 0);
        #1;
        summary();
        $finish;
    end

endmodule